// File: doc/BRIEF.md
# Two-Port Serial Button Reader

This block sits on a processor bus and serves two game controllers, each with eight buttons. Software writes a single strobe bit to a shared control register. While that bit is 1, both ports keep reloading from their parallel button inputs. When software writes it back to 0, the button states from that clock edge are frozen into one shift register per port.

After the freeze, each read access to a port hands back one button in bit 0 of the read data, and the next button moves into place when the access ends. Reading a port has no effect on the other port, because each port has its own shift register.

The parallel button vector uses index 0 for the primary action button. Index 1 is the secondary action button, 2 is the select button and 3 is the start button. Indices 4 to 7 are up, down, left and right, in that order. Software receives the buttons in ascending index order.

Top module: `pad_serial_port`

## Requirements
- R1: After reset the strobe bit is 0 and both shift registers hold all ones, so a read of either port returns 1 in bit 0.
- R2: A write with `wr_bit`=1 sets the strobe. While the strobe is 1, a read of a port returns that port's live index-0 input in bit 0, and the read does not advance the port.
- R3: A write with `wr_bit`=0 clears the strobe. The value frozen into each port is the parallel input sampled at the clock edge that accepts this write.
- R4: After the freeze, successive reads of a port return input indices 0, 1, 2, …, 7 in bit 0, in that order.
- R5: Once all eight buttons have been read, every further read of that port returns 1 in bit 0 until the next strobe.
- R6: A port advances once per read access, at the clock edge after its read strobe drops. A read held for several cycles returns the same value throughout.
- R7: The two ports advance independently. Reads of one port never change the bit sequence of the other port.
- R8: `rd_data` bits above bit 0 are always 0. `rd_data` is all zero when neither read strobe is high. When both read strobes are high, port 0 is returned.
- R9: Changes on the parallel inputs after the freeze have no effect on the bits that are read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe to the shared strobe register |
| wr_bit | input | 1 | Strobe value written (bit 0 of the bus data) |
| rd_en_p0 | input | 1 | Read strobe for port 0 |
| rd_en_p1 | input | 1 | Read strobe for port 1 |
| pad0_btn | input | BTN_COUNT | Parallel button inputs of controller 0 |
| pad1_btn | input | BTN_COUNT | Parallel button inputs of controller 1 |
| rd_data | output | DATA_W | Read data; bit 0 carries the current button |

## Verification
The bench builds the block with the default values: eight buttons per port and an eight-bit read bus. With these values a full shift sequence is only nine reads long, so the fill-with-ones tail can be reached for every table vector. The upper read-data bits make up a seven-bit field that the bench can check for zero on every access. Interleaving port 0 and port 1 reads in the same sequence exposes any coupling between the two shift registers.

// File: rtl/pad_serial_port.sv
module pad_serial_port #(
  parameter int BTN_COUNT = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_bit,
  input  logic                 rd_en_p0,
  input  logic                 rd_en_p1,
  input  logic [BTN_COUNT-1:0] pad0_btn,
  input  logic [BTN_COUNT-1:0] pad1_btn,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int NPORT = 2;

  logic                 strobe_q;
  logic [NPORT-1:0]     rd_req, rd_q, rd_fall, cur_bit;
  logic [BTN_COUNT-1:0] pad_in [NPORT];
  logic [BTN_COUNT-1:0] shr    [NPORT];
  logic                 sel_bit;

  assign pad_in[0] = pad0_btn;
  assign pad_in[1] = pad1_btn;
  assign rd_req    = {rd_en_p1, rd_en_p0};
  assign rd_fall   = rd_q & ~rd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (wr_en) strobe_q <= wr_bit;
      rd_q <= rd_req;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)          shr[p] <= '1;
      else if (strobe_q)   shr[p] <= pad_in[p];
      else if (rd_fall[p]) shr[p] <= {1'b1, shr[p][BTN_COUNT-1:1]};
    end
    assign cur_bit[p] = strobe_q ? pad_in[p][0] : shr[p][0];
  end

  assign sel_bit = rd_en_p0 ? cur_bit[0] : (rd_en_p1 ? cur_bit[1] : 1'b0);
  assign rd_data = {{(DATA_W-1){1'b0}}, sel_bit};

endmodule

module pad_serial_port_chk #(
  parameter int BTN_COUNT = 8,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en_p0,
  input logic                 rd_en_p1,
  input logic [BTN_COUNT-1:0] pad0_btn,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 strobe,
  input logic                 rd1_q,
  input logic [BTN_COUNT-1:0] shr1
);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:1] == '0); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_p0 && !rd_en_p1) |-> rd_data == '0); // R8
  AST_LIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && rd_en_p0) |-> rd_data[0] == pad0_btn[0]); // R2
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_p0 && $past(rd_en_p0) && !strobe && !$past(strobe)) |-> $stable(rd_data)); // R6
  AST_PORT1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !rd_en_p1 && !rd1_q) |=> $stable(shr1)); // R7
  AST_FILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && rd1_q && !rd_en_p1) |=> shr1[BTN_COUNT-1]); // R5

endmodule

bind pad_serial_port pad_serial_port_chk #(.BTN_COUNT(BTN_COUNT), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en_p0(rd_en_p0), .rd_en_p1(rd_en_p1),
  .pad0_btn(pad0_btn), .rd_data(rd_data), .strobe(strobe_q),
  .rd1_q(rd_q[1]), .shr1(shr[1])
);

// File: tb/pad_serial_port_tb.sv
module pad_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int DW = 8;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h8001, 16'h3CC3};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
  logic rd_en_p0 = 1'b0, rd_en_p1 = 1'b0;
  logic [NB-1:0] pad0_btn = '0, pad1_btn = '0;
  logic [DW-1:0] rd_data;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_serial_port #(.BTN_COUNT(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en_p0(rd_en_p0), .rd_en_p1(rd_en_p1),
    .pad0_btn(pad0_btn), .pad1_btn(pad1_btn), .rd_data(rd_data));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic b);
    @(negedge clk); wr_en = 1'b1; wr_bit = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int p, output logic [DW-1:0] v);
    @(negedge clk);
    if (p == 0) rd_en_p0 = 1'b1; else rd_en_p1 = 1'b1;
    #1 v = rd_data;
    @(negedge clk); rd_en_p0 = 1'b0; rd_en_p1 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R8 idle zero", rd_data, 8'h00);
    rd(0, v); check("R1 port0 after reset", v, 8'h01);
    rd(1, v); check("R1 port1 after reset", v, 8'h01);

    for (int k = 0; k < NVEC; k++) begin
      pad0_btn = VEC[k][7:0]; pad1_btn = VEC[k][15:8];
      wr(1'b1); wr(1'b0);
      pad0_btn = ~VEC[k][7:0]; pad1_btn = ~VEC[k][15:8];
      for (int i = 0; i < NB; i++) begin
        rd(0, v); check("R4 R3 R9 port0 order", v, {7'b0, VEC[k][i]});
        rd(1, v); check("R4 R7 port1 order", v, {7'b0, VEC[k][8+i]});
      end
      rd(0, v); check("R5 port0 tail", v, 8'h01);
      rd(1, v); check("R5 port1 tail", v, 8'h01);
      rd(1, v); check("R5 port1 tail again", v, 8'h01);
    end

    pad0_btn = 8'h01;
    wr(1'b1);
    rd(0, v); check("R2 live A high", v, 8'h01);
    rd(0, v); check("R2 no shift", v, 8'h01);
    pad0_btn = 8'h02;
    rd(0, v); check("R2 live A low", v, 8'h00);
    wr(1'b0);
    rd(0, v); check("R2 R3 first after hold", v, 8'h00);
    rd(0, v); check("R2 second after hold", v, 8'h01);

    pad0_btn = 8'h02;
    wr(1'b1); wr(1'b0);
    @(negedge clk); rd_en_p0 = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1 check("R6 held read stable", rd_data, 8'h00);
      @(negedge clk);
    end
    rd_en_p0 = 1'b0;
    rd(0, v); check("R6 single advance", v, 8'h01);
    rd(0, v); check("R6 next bit", v, 8'h00);

    pad0_btn = 8'h01; pad1_btn = 8'h02;
    wr(1'b1); wr(1'b0);
    @(negedge clk); rd_en_p0 = 1'b1; rd_en_p1 = 1'b1;
    #1 check("R8 port0 priority", rd_data, 8'h01);
    @(negedge clk); rd_en_p0 = 1'b0; rd_en_p1 = 1'b0;
    rd(1, v); check("R8 R7 port1 advanced once", v, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule